// File: doc/BRIEF.md
# Beat Interval Measurement Unit

This block turns a single conditioned pulse line from an analog front end into a measured heartbeat interval. The interval is counted in cycles of a slow system clock, nominally 960 Hz. Two flops synchronise the pulse line. A rising edge of the synchronised level then becomes a one-cycle beat strobe. A saturating counter tracks the cycles since the last beat. On each beat the counter value is captured and the counter restarts from zero.

Each captured interval is sorted into one of three outcomes:
- **Timeout:** the counter reached full scale. A downstream rate divider should then show a zero rate.
- **Error:** the interval is shorter than a plausible minimum and is treated as noise.
- **Valid:** the interval lies between the two and is announced with a one-cycle strobe.

The rate division and the analog conditioning sit outside this block.

Top module: `beat_interval_unit`

## Requirements
- R1: A synchronous active-high reset clears the counter and the interval register, and holds `valid_o`, `timeout_o` and `error_o` low. On the cycle after reset, `interval_q` is 0 and all three flags are 0.
- R2: A rising edge on `pulse_in` is captured at the third rising clock edge after the input change. The new `interval_q` and flags are visible after that edge: two synchroniser stages, one edge-detect stage and the capture register.
- R3: On each beat, the count of cycles since the previous beat (or since reset) is loaded into `interval_q`, and the counter is cleared to zero. When input rising edges are G clock cycles apart, `interval_q` becomes G-1, limited to full scale.
- R4: The counter stops at full scale, 2^CNT_W-1 (2047 at the default width), and stays there until the next beat. A beat taken at full scale loads exactly 2^CNT_W-1.
- R5: `timeout_o` is high exactly while the counter sits at full scale. It drops at the edge that captures the next beat.
- R6: When a captured interval is below MIN_INTERVAL (default 230), `error_o` rises with the capture. It stays high until the next capture, which re-evaluates it.
- R7: `valid_o` is a single-cycle pulse issued with a capture only when the interval is at least MIN_INTERVAL and the counter was not at full scale.
- R8: Holding `pulse_in` high for several cycles yields only one beat. No second capture or `valid_o` pulse follows until the input has gone low and risen again.
- R9: `valid_o` and `error_o` are never high together. A capture taken at full scale raises neither flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pulse_in | input | 1 | Asynchronous conditioned beat level from the front end |
| interval_q | output | CNT_W | Last captured beat interval in clock cycles |
| valid_o | output | 1 | One-cycle strobe for a plausible captured interval |
| timeout_o | output | 1 | Counter at full scale; no beat within range |
| error_o | output | 1 | Last captured interval was shorter than MIN_INTERVAL |

## Verification
The bench builds the unit with CNT_W=9 and MIN_INTERVAL=60. Full scale is then 511 cycles, so saturation, the timeout flag and a capture taken at full scale all occur within a few hundred cycles of waiting. Random beat spacings from 5 to 700 cycles therefore land in all three outcome bands. Directed spacings sit on each side of both the MIN_INTERVAL boundary and the full-scale boundary. Random hold lengths of the input level exercise the rule that only a rising edge counts as a beat.

// File: rtl/biu_pkg.sv
package biu_pkg;

  typedef enum logic [1:0] {
    OUT_NONE    = 2'd0,
    OUT_VALID   = 2'd1,
    OUT_SHORT   = 2'd2,
    OUT_TIMEOUT = 2'd3
  } beat_outcome_e;

  // Sort one capture: saturation wins over the short-interval test.
  function automatic beat_outcome_e classify(input logic beat,
                                             input logic saturated,
                                             input logic too_short);
    beat_outcome_e r;
    if (!beat)          r = OUT_NONE;
    else if (saturated) r = OUT_TIMEOUT;
    else if (too_short) r = OUT_SHORT;
    else                r = OUT_VALID;
    return r;
  endfunction

endpackage

// File: rtl/biu_sync_edge.sv
module biu_sync_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic beat_o
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] stage_q;
  logic                   prev_q;

  generate
    genvar gi;
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[0] <= 1'b0;
          else     stage_q[0] <= async_in;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) stage_q[gi] <= 1'b0;
          else     stage_q[gi] <= stage_q[gi-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= stage_q[LAST];
  end

  // Rising edge of the synchronised level: one cycle wide.
  assign beat_o = stage_q[LAST] & ~prev_q;

endmodule

// File: rtl/biu_interval_counter.sv
module biu_interval_counter #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             beat,
  output logic [CNT_W-1:0] count_q,
  output logic [CNT_W-1:0] interval_q,
  output logic             at_max
);

  localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

  // Saturating increment: stops at full scale.
  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == FULL) ? FULL : v + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q    <= '0;
      interval_q <= '0;
    end else if (beat) begin
      interval_q <= count_q;
      count_q    <= '0;
    end else begin
      count_q    <= sat_inc(count_q);
    end
  end

  assign at_max = (count_q == FULL);

endmodule

// File: rtl/biu_qualifier.sv
module biu_qualifier #(
  parameter int CNT_W        = 11,
  parameter int MIN_INTERVAL = 230
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             beat,
  input  logic             saturated,
  input  logic [CNT_W-1:0] count,
  output logic             valid_o,
  output logic             error_o
);
  import biu_pkg::*;

  localparam logic [CNT_W-1:0] MIN_L = CNT_W'(MIN_INTERVAL);

  function automatic logic below_min(input logic [CNT_W-1:0] v);
    return v < MIN_L;
  endfunction

  beat_outcome_e outcome;

  assign outcome = classify(beat, saturated, below_min(count));

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      error_o <= 1'b0;
    end else begin
      valid_o <= (outcome == OUT_VALID);
      if (beat) error_o <= (outcome == OUT_SHORT);
    end
  end

endmodule

// File: rtl/beat_interval_unit.sv
module beat_interval_unit #(
  parameter int CNT_W        = 11,
  parameter int MIN_INTERVAL = 230,
  parameter int SYNC_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pulse_in,
  output logic [CNT_W-1:0] interval_q,
  output logic             valid_o,
  output logic             timeout_o,
  output logic             error_o
);

  logic             beat_w;
  logic             sat_w;
  logic [CNT_W-1:0] cnt_q;

  biu_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rst      (rst),
    .async_in (pulse_in),
    .beat_o   (beat_w)
  );

  biu_interval_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .beat       (beat_w),
    .count_q    (cnt_q),
    .interval_q (interval_q),
    .at_max     (sat_w)
  );

  biu_qualifier #(.CNT_W(CNT_W), .MIN_INTERVAL(MIN_INTERVAL)) u_qual (
    .clk       (clk),
    .rst       (rst),
    .beat      (beat_w),
    .saturated (sat_w),
    .count     (cnt_q),
    .valid_o   (valid_o),
    .error_o   (error_o)
  );

  assign timeout_o = sat_w;

endmodule

// File: rtl/biu_checker.sv
module biu_checker #(
  parameter int CNT_W        = 11,
  parameter int MIN_INTERVAL = 230
) (
  input logic             clk,
  input logic             rst,
  input logic             beat,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] interval_q,
  input logic             valid_o,
  input logic             timeout_o,
  input logic             error_o
);

  localparam logic [CNT_W-1:0] FULL  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] MIN_L = CNT_W'(MIN_INTERVAL);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (interval_q == '0 && !valid_o && !timeout_o && !error_o));

  // R2
  beat_single_chk: assert property (@(posedge clk) disable iff (rst)
    beat |=> !beat);

  // R3
  capture_clear_chk: assert property (@(posedge clk) disable iff (rst)
    beat |=> (count == '0 && interval_q == $past(count)));

  // R4
  sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (count == FULL && !beat) |=> (count == FULL));

  // R5
  timeout_drop_chk: assert property (@(posedge clk) disable iff (rst)
    beat |=> !timeout_o);

  // R6
  short_err_chk: assert property (@(posedge clk) disable iff (rst)
    (beat && count < MIN_L) |=> error_o);

  // R7
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  // R7
  valid_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (beat && (count < MIN_L || count == FULL)) |=> !valid_o);

  // R9
  excl_flags_chk: assert property (@(posedge clk) disable iff (rst)
    !(valid_o && error_o));

endmodule

bind beat_interval_unit biu_checker #(
  .CNT_W(CNT_W), .MIN_INTERVAL(MIN_INTERVAL)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .beat       (beat_w),
  .count      (cnt_q),
  .interval_q (interval_q),
  .valid_o    (valid_o),
  .timeout_o  (timeout_o),
  .error_o    (error_o)
);

// File: tb/beat_interval_unit_test.sv
module beat_interval_unit_test;

  localparam int CNT_W = 9;
  localparam int MIN_I = 60;
  localparam int MAXV  = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             pulse_in = 1'b0;
  logic [CNT_W-1:0] interval_q;
  logic             valid_o, timeout_o, error_o;

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;
  int last_latch = 0;
  logic prev_err = 1'b0;

  beat_interval_unit #(.CNT_W(CNT_W), .MIN_INTERVAL(MIN_I)) uut (
    .clk(clk), .rst(rst), .pulse_in(pulse_in),
    .interval_q(interval_q), .valid_o(valid_o),
    .timeout_o(timeout_o), .error_o(error_o)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int exp_interval(input int gap);
    return (gap - 1 >= MAXV) ? MAXV : gap - 1;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    pulse_in = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1: all outputs cleared while reset is applied
    check("R1 interval", int'(interval_q), 0);
    check("R1 valid",    int'(valid_o), 0);
    check("R1 timeout",  int'(timeout_o), 0);
    check("R1 error",    int'(error_o), 0);
    rst = 1'b0;
    last_latch = cyc;
    prev_err = 1'b0;
  endtask

  // Rise on pulse_in now, hold h cycles, total spacing g cycles (g >= 5).
  task automatic pulse_gap(input int g, input int h);
    int e, gap;
    logic sat, ev, ee;
    for (int i = 0; i < g; i++) begin
      pulse_in = (i < h);
      if (i == 2) begin
        // R5: timeout exactly while the count sits at full scale
        check("R5 timeout before beat", int'(timeout_o),
              ((cyc - last_latch) >= MAXV) ? 1 : 0);
        // R6: error held from previous capture
        check("R6 error held", int'(error_o), int'(prev_err));
      end
      if (i == 3) begin
        gap = cyc - last_latch;
        e   = exp_interval(gap);
        sat = (gap - 1 >= MAXV);
        ev  = !sat && (e >= MIN_I);
        ee  = !sat && (e < MIN_I);
        // R2 / R3 / R4: captured value three edges after the rise
        check(sat ? "R4 saturated capture" : "R3 captured interval",
              int'(interval_q), e);
        check("R7 valid", int'(valid_o), int'(ev));
        check(sat ? "R9 error on saturated" : "R6 error", int'(error_o), int'(ee));
        check("R5 timeout cleared", int'(timeout_o), 0);
        last_latch = cyc;
        prev_err = ee;
      end
      if (i == 4) begin
        // R7 / R8: single strobe even if input is still high
        check("R8 no retrigger valid", int'(valid_o), 0);
        check("R8 interval unchanged", int'(interval_q), e);
      end
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  initial begin
    void'($urandom(32'd20240517));
    do_reset();
    // directed corners
    pulse_gap(40, 1);
    pulse_gap(5, 4);             // short: interval 4
    pulse_gap(MIN_I + 1, 2);     // exactly MIN_I: valid
    pulse_gap(MIN_I, 3);         // MIN_I-1: error
    pulse_gap(MIN_I + 1, 4);     // error clears
    pulse_gap(MAXV, 1);          // MAXV-1: valid, no timeout
    pulse_gap(MAXV + 1, 2);      // reaches full scale: timeout capture
    pulse_gap(MAXV + 300, 3);    // long wait
    pulse_gap(8, 1);
    do_reset();
    pulse_gap(MIN_I + 10, 1);
    // constrained random spacings and hold lengths
    for (int k = 0; k < 60; k++)
      pulse_gap(5 + int'($urandom_range(695)), 1 + int'($urandom_range(3)));
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(10 * 150000);
    miscompares++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule